// File: doc/BRIEF.md
# Low-Power Read Turnaround Supervisor

This block supervises the low-power read handshake of a serial display host link. When the transmit side reports that a read request, or a command that enables the tear-effect signal, has left the link, the block waits for a programmed hold interval. It then asks the physical layer to reverse the direction of the lane. Two independent timers watch what happens next. The first limits how long the lane reversal may take. The second limits how long the receive-valid indicator may stay low once the physical layer has entered low-power receive mode.

Each outcome sets a sticky flag: a turnaround timeout, a receive timeout, or read data ready. Software clears a flag with a one-cycle write-one-to-clear strobe. A single interrupt line reports the enabled flags.

All delays are counted in escape-clock ticks, which arrive as one-cycle enable pulses in the system clock domain. A second read request that arrives while a handshake is in progress is remembered and served once the block is idle again.

Top module: `lprd_turnaround`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bta_req`, `flags` and `irq` are all zero.
- R2: With `esc_tick` high every cycle, `bta_req` rises on the clock edge H+1 edges after the edge that samples `pkt_sent`, where H is `hold_cfg`. While `esc_tick` is low the hold delay does not advance.
- R3: If `phy_bta_ack` is sampled high while `bta_req` is high, `bta_req` is low from the next edge on and no error flag is set.
- R4: If no acknowledge arrives, `bta_req` stays high for exactly B+1 cycles (B = `bta_to_cfg`, one tick per cycle). It then falls, and flag bit 0 (turnaround timeout) is set on the same edge.
- R5: After the acknowledge, the receive timer starts on the edge that first samples `rx_lpdt` high. If `rx_valid` has not been seen, flag bit 1 (receive timeout) is set R+1 edges later (R = `rx_to_cfg`). The timer does not run before `rx_lpdt` is seen.
- R6: `rx_valid` sampled high while waiting for receive data sets flag bit 2 (read data ready), sets no error flag, and returns the block to idle.
- R7: A `pkt_sent` pulse that arrives while a handshake is in progress is held. A new hold delay and turnaround request follow once the block returns to idle. With no request pending, `bta_req` stays low.
- R8: A `flag_clr` bit that is high clears the matching flag on the next edge. A set of the same flag on the same edge wins over the clear, and flags whose clear bit is low are kept.
- R9: `irq` equals the OR of `flags & irq_en` one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| esc_tick | input | 1 | One-cycle pulse per escape-clock period |
| pkt_sent | input | 1 | Pulse: read request or tear-enable command has been transmitted |
| hold_cfg | input | HOLD_W (16) | Ticks between packet end and turnaround request |
| bta_to_cfg | input | BTA_W (8) | Turnaround timeout in ticks |
| rx_to_cfg | input | RX_W (16) | Receive-valid timeout in ticks |
| phy_bta_ack | input | 1 | Physical layer reports that the direction change completed |
| rx_lpdt | input | 1 | Physical layer is in low-power receive mode |
| rx_valid | input | 1 | Received data valid |
| irq_en | input | 3 | Interrupt enable per flag |
| flag_clr | input | 3 | Write-one-to-clear strobes per flag |
| bta_req | output | 1 | Turnaround request to the physical layer |
| flags | output | 3 | Bit 0 turnaround timeout, bit 1 receive timeout, bit 2 read ready |
| irq | output | 1 | Interrupt |

## Verification
The hardest situation to reach is a second read request that arrives in the middle of a turnaround. It must be neither lost nor started early. The stimulus pulses `pkt_sent` while `bta_req` is high, lets the turnaround time out, and then expects a fresh request to follow the timeout. The bench also sweeps the hold, turnaround and receive limits over 0 to 7 and checks each measured cycle count against the formula. It stalls `esc_tick` to show that the hold delay does not advance, and lines up a flag set with its clear strobe on the same edge.

// File: rtl/lprd_pkg.sv
package lprd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_TURN = 2'd2,
    ST_RXW  = 2'd3
  } lprd_state_t;

  localparam int NFLAG    = 3;
  localparam int F_BTA_TO = 0;
  localparam int F_RX_TO  = 1;
  localparam int F_RDY    = 2;
endpackage

// File: rtl/lprd_timer.sv
module lprd_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lprd_flags.sv
module lprd_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (set[i]) begin
        flags[i] <= 1'b1;
      end else if (clr[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= |(flags & en);
    end
  end
endmodule

// File: rtl/lprd_seq.sv
module lprd_seq
  import lprd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pkt_sent,
  input  logic        hold_done,
  input  logic        bta_done,
  input  logic        rx_done,
  input  logic        phy_bta_ack,
  input  logic        rx_lpdt,
  input  logic        rx_valid,
  output lprd_state_t state,
  output logic        armed,
  output logic        bta_req,
  output logic [NFLAG-1:0] set_flag
);
  lprd_state_t nxt;
  logic        pend;

  always_comb begin
    nxt      = state;
    set_flag = '0;
    unique case (state)
      ST_IDLE: if (pkt_sent || pend) nxt = ST_HOLD;
      ST_HOLD: if (hold_done) nxt = ST_TURN;
      ST_TURN: begin
        if (phy_bta_ack) begin
          nxt = ST_RXW;
        end else if (bta_done) begin
          nxt = ST_IDLE;
          set_flag[F_BTA_TO] = 1'b1;
        end
      end
      ST_RXW: begin
        if (rx_valid) begin
          nxt = ST_IDLE;
          set_flag[F_RDY] = 1'b1;
        end else if (armed && rx_done) begin
          nxt = ST_IDLE;
          set_flag[F_RX_TO] = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= 1'b0;
      armed   <= 1'b0;
      bta_req <= 1'b0;
    end else begin
      state   <= nxt;
      bta_req <= (nxt == ST_TURN);
      armed   <= (state == ST_RXW) && (nxt == ST_RXW) && (armed || rx_lpdt);
      if (state == ST_IDLE) begin
        pend <= 1'b0;
      end else if (pkt_sent) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lprd_turnaround.sv
module lprd_turnaround
  import lprd_pkg::*;
#(
  parameter int HOLD_W = 16,
  parameter int BTA_W  = 8,
  parameter int RX_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              esc_tick,
  input  logic              pkt_sent,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic [BTA_W-1:0]  bta_to_cfg,
  input  logic [RX_W-1:0]   rx_to_cfg,
  input  logic              phy_bta_ack,
  input  logic              rx_lpdt,
  input  logic              rx_valid,
  input  logic [2:0]        irq_en,
  input  logic [2:0]        flag_clr,
  output logic              bta_req,
  output logic [2:0]        flags,
  output logic              irq
);
  lprd_state_t      state;
  logic             armed;
  logic             hold_done, bta_done, rx_done;
  logic [NFLAG-1:0] set_flag;

  lprd_timer #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .clr(state != ST_HOLD), .tick(esc_tick),
    .limit(hold_cfg), .done(hold_done)
  );

  lprd_timer #(.W(BTA_W)) u_bta (
    .clk(clk), .rst(rst), .clr(state != ST_TURN), .tick(esc_tick),
    .limit(bta_to_cfg), .done(bta_done)
  );

  lprd_timer #(.W(RX_W)) u_rx (
    .clk(clk), .rst(rst), .clr(!((state == ST_RXW) && armed)), .tick(esc_tick),
    .limit(rx_to_cfg), .done(rx_done)
  );

  lprd_seq u_seq (
    .clk(clk), .rst(rst), .pkt_sent(pkt_sent),
    .hold_done(hold_done), .bta_done(bta_done), .rx_done(rx_done),
    .phy_bta_ack(phy_bta_ack), .rx_lpdt(rx_lpdt), .rx_valid(rx_valid),
    .state(state), .armed(armed), .bta_req(bta_req), .set_flag(set_flag)
  );

  lprd_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(set_flag), .clr(flag_clr), .en(irq_en),
    .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/lprd_turnaround_chk.sv
module lprd_turnaround_chk (
  input logic       clk,
  input logic       rst,
  input logic       phy_bta_ack,
  input logic       rx_valid,
  input logic [2:0] irq_en,
  input logic [2:0] flag_clr,
  input logic       bta_req,
  input logic [2:0] flags,
  input logic       irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (flags == 3'b000) && !bta_req && !irq);

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bta_req && phy_bta_ack) |=> !bta_req);

  // R4
  bta_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(bta_req) && !$past(phy_bta_ack));

  // R5
  rx_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[1]) |-> !$past(rx_valid));

  // R6
  rdy_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[2]) |-> $past(rx_valid));

  // R8
  keep_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !flag_clr[0]) |=> flags[0]);

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flags & irq_en))));
endmodule

bind lprd_turnaround lprd_turnaround_chk u_chk (
  .clk(clk), .rst(rst), .phy_bta_ack(phy_bta_ack), .rx_valid(rx_valid),
  .irq_en(irq_en), .flag_clr(flag_clr), .bta_req(bta_req),
  .flags(flags), .irq(irq)
);

// File: tb/sim_lprd_turnaround.sv
module sim_lprd_turnaround;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        esc_tick = 1'b1;
  logic        pkt_sent = 1'b0;
  logic [15:0] hold_cfg = '0;
  logic [7:0]  bta_to_cfg = '0;
  logic [15:0] rx_to_cfg = '0;
  logic        phy_bta_ack = 1'b0;
  logic        rx_lpdt = 1'b0;
  logic        rx_valid = 1'b0;
  logic [2:0]  irq_en = '0;
  logic [2:0]  flag_clr = '0;
  logic        bta_req;
  logic [2:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lprd_turnaround u0 (
    .clk(clk), .rst(rst), .esc_tick(esc_tick), .pkt_sent(pkt_sent),
    .hold_cfg(hold_cfg), .bta_to_cfg(bta_to_cfg), .rx_to_cfg(rx_to_cfg),
    .phy_bta_ack(phy_bta_ack), .rx_lpdt(rx_lpdt), .rx_valid(rx_valid),
    .irq_en(irq_en), .flag_clr(flag_clr), .bta_req(bta_req),
    .flags(flags), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    flag_clr = 3'b111;
    step();
    flag_clr = 3'b000;
  endtask

  // Start a packet and return the number of edges after the sampling edge until bta_req rises
  task automatic start_pkt(output int n);
    pkt_sent = 1'b1;
    step();
    pkt_sent = 1'b0;
    n = 0;
    while (!bta_req && n < 100) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    step();
    // R1 reset state
    check(bta_req == 1'b0 && flags == 3'b000 && irq == 1'b0, "R1", {29'd0, flags}, 0);
    rst = 1'b0;
    step();
    check(bta_req == 1'b0 && flags == 3'b000 && irq == 1'b0, "R1", {29'd0, flags}, 0);

    // R2 hold delay sweep, R3 ack, R6 ready
    bta_to_cfg = 8'd200;
    for (int h = 0; h < 8; h++) begin
      hold_cfg = 16'(h);
      start_pkt(n);
      check(n == h + 1, "R2", n, h + 1);
      phy_bta_ack = 1'b1;
      step();
      phy_bta_ack = 1'b0;
      check(!bta_req && flags == 3'b000, "R3", {31'd0, bta_req}, 0);
      rx_valid = 1'b1;
      step();
      rx_valid = 1'b0;
      check(flags == 3'b100, "R6", {29'd0, flags}, 4);
      clear_all();
      check(flags == 3'b000, "R8", {29'd0, flags}, 0);
    end

    // R2 stalled ticks do not advance the hold
    hold_cfg = 16'd3;
    esc_tick = 1'b0;
    pkt_sent = 1'b1;
    step();
    pkt_sent = 1'b0;
    for (int i = 0; i < 20; i++) step();
    check(!bta_req, "R2", {31'd0, bta_req}, 0);
    esc_tick = 1'b1;
    n = 0;
    while (!bta_req && n < 100) begin
      step();
      n++;
    end
    check(n == 4, "R2", n, 4);
    phy_bta_ack = 1'b1;
    step();
    phy_bta_ack = 1'b0;
    rx_valid = 1'b1;
    step();
    rx_valid = 1'b0;
    clear_all();

    // R4 turnaround timeout sweep, R9 irq
    hold_cfg = 16'd0;
    irq_en = 3'b001;
    for (int b = 0; b < 8; b++) begin
      bta_to_cfg = 8'(b);
      start_pkt(n);
      n = 0;
      while (bta_req && n < 300) begin
        n++;
        step();
      end
      check(n == b + 1, "R4", n, b + 1);
      check(flags == 3'b001, "R4", {29'd0, flags}, 1);
      step();
      check(irq == 1'b1, "R9", {31'd0, irq}, 1);
      clear_all();
      step();
      check(irq == 1'b0, "R9", {31'd0, irq}, 0);
    end

    // R5 receive timeout sweep
    bta_to_cfg = 8'd200;
    irq_en = 3'b100;
    for (int r = 0; r < 8; r++) begin
      rx_to_cfg = 16'(r);
      start_pkt(n);
      phy_bta_ack = 1'b1;
      step();
      phy_bta_ack = 1'b0;
      for (int i = 0; i < 12; i++) step();
      check(flags == 3'b000, "R5", {29'd0, flags}, 0);
      rx_lpdt = 1'b1;
      step();
      n = 0;
      while (!flags[1] && n < 100) begin
        step();
        n++;
      end
      rx_lpdt = 1'b0;
      check(n == r + 1, "R5", n, r + 1);
      check(flags == 3'b010, "R5", {29'd0, flags}, 2);
      step();
      check(irq == 1'b0, "R9", {31'd0, irq}, 0);
      clear_all();
    end

    // R7 request during turnaround is held and served later
    bta_to_cfg = 8'd5;
    start_pkt(n);
    pkt_sent = 1'b1;
    step();
    pkt_sent = 1'b0;
    n = 0;
    while (!flags[0] && n < 100) begin
      step();
      n++;
    end
    check(flags[0] && !bta_req, "R7", {31'd0, bta_req}, 0);
    n = 0;
    while (!bta_req && n < 100) begin
      step();
      n++;
    end
    check(n == 2, "R7", n, 2);
    // R8 set wins over a clear on the same edge
    phy_bta_ack = 1'b1;
    step();
    phy_bta_ack = 1'b0;
    rx_valid = 1'b1;
    flag_clr = 3'b100;
    step();
    rx_valid = 1'b0;
    flag_clr = 3'b000;
    check(flags == 3'b101, "R8", {29'd0, flags}, 5);
    flag_clr = 3'b001;
    step();
    flag_clr = 3'b000;
    check(flags == 3'b100, "R8", {29'd0, flags}, 4);
    clear_all();
    // R7 nothing pending: no further request
    n = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (bta_req) n++;
    end
    check(n == 0, "R7", n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule